// File: doc/BRIEF.md
# Battery Charger Event Interrupt Controller

This block turns slow status levels from a battery charger into processor interrupts. Five single-bit conditions come in: supply input valid, battery temperature within limits, charger at end of charge, precharge timer expired and total-charge timer expired. It also takes a two-bit charge-state code and a supply-kind detect level. The conditions form four event groups: charge-complete, supply, temperature and timer. Each group can raise an interrupt when its condition is entered, when it is left, or on both.

Software sees three byte registers through a plain read/write strobe port. The status register holds a pending flag for each group in its upper nibble and the live condition levels in its lower nibble. Writing the upper nibble arms the groups. Reading the register returns the pending flags and clears them. The edge-select register holds one enable bit per direction and source. A read-only register reports the charge state and the supply-kind level.

The interrupt output is active low. It stays low while any flag remains unread. The single-bit inputs pass through a synchroniser of `SYNC_STAGES` flops. The charge-state code is assumed to come from logic on the same clock and is registered once.

Top module: `chg_evt_irq_ctrl`

## Requirements
- R1: After reset all pending flags, arm bits and edge enables are 0, and `irq_n_o` is 1. A status read with all inputs low returns 0x00, and an edge-select read returns 0x00.
- R2: Status bits [3:0] show the synchronised levels. Bit 3 is precharge-expired OR total-expired, bit 2 is temperature-ok, bit 1 is supply-valid and bit 0 is end-of-charge. Each level appears `SYNC_STAGES` clock edges after the input changes.
- R3: A rising level sets the group's flag when the group's arm bit and the matching rise enable are both 1. Flag positions are bit 7 timer, bit 6 temperature, bit 5 supply and bit 4 charge-complete. The rise enables in the edge-select register are bit 6 temperature, bit 5 supply and bit 4 charge-complete. The flag is set `SYNC_STAGES`+1 edges after the input change.
- R4: A falling level sets the group's flag when the arm bit and the matching fall enable are both 1. The fall enables are bit 2 temperature, bit 1 supply and bit 0 charge-complete.
- R5: No flag is set when the group's arm bit is 0, whatever the edge enables are. No flag is set when the matching edge enable is 0.
- R6: A status read returns the pending flags in [7:4] and clears them. A second read with no new event returns 0 in [7:4].
- R7: If an enabled event reaches a flag in the same cycle as the read that clears it, the flag stays set afterwards. That read returns the flag's old value.
- R8: `irq_n_o` is 0 while any flag is set and 1 when no flag is set.
- R9: The edge-select register reads back its written value. A write to the status register loads the arm bits from data bits [7:4] and ignores bits [3:0].
- R10: The state register returns the charge state in bits [5:4] and the supply-kind level in bit 1; its other bits are 0. Writes to it change nothing. Reads of an unmapped address return 0.
- R11: The timer flag (status bit 7) is set by a precharge-timer rise when edge-select bit 3 is 1, and by a total-timer rise when edge-select bit 7 is 1. Each enable acts only on its own timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_ok_i | input | 1 | Supply input valid level |
| tmp_ok_i | input | 1 | Battery temperature in range level |
| eoc_i | input | 1 | Charger in end-of-charge state |
| pre_tmo_i | input | 1 | Precharge timer expired |
| tot_tmo_i | input | 1 | Total-charge timer expired |
| src_kind_i | input | 1 | Supply-kind detect level |
| chg_state_i | input | 2 | Charge-state code from the charger |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_rd_i | input | 1 | Read strobe, one cycle |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the strobe cycle, 0 otherwise |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A wrong edge detector or synchroniser shows up in two ways. A flag appears on a level that did not change, or the flag appears at another edge than `SYNC_STAGES`+1 edges after the input change. The bench reads at exactly that cycle. A lost clear shows as the same flag returned by two reads in a row. An event-loses-to-read bug shows as a missing flag and a high `irq_n_o` one cycle after the coinciding read. Arm or enable bits that are stuck or swapped show up on the next edge of the affected source: either an unexpected flag or a missing one.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int NUM_GRP = 4;
    localparam int NUM_SRC = 6;
    localparam int DATA_W  = 8;

    // source indices inside the synchronised vector
    localparam int SRC_EOC  = 0;
    localparam int SRC_SUP  = 1;
    localparam int SRC_TMP  = 2;
    localparam int SRC_PRE  = 3;
    localparam int SRC_TOT  = 4;
    localparam int SRC_KIND = 5;

    // group indices, equal to flag position minus 4 in the status byte
    localparam int GRP_EOC = 0;
    localparam int GRP_SUP = 1;
    localparam int GRP_TMP = 2;
    localparam int GRP_TMR = 3;

    // edge-select register, most significant bit first
    typedef struct packed {
        logic tot_rise;
        logic tmp_rise;
        logic sup_rise;
        logic eoc_rise;
        logic pre_rise;
        logic tmp_fall;
        logic sup_fall;
        logic eoc_fall;
    } edge_en_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
        logic [NUM_SRC-1:0] rise;
        logic [NUM_SRC-1:0] fall;
    } src_view_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_STAT,
        RSEL_CTRL,
        RSEL_STATE
    } rsel_e;

    function automatic logic [NUM_GRP-1:0] group_levels(input logic [NUM_SRC-1:0] l);
        logic [NUM_GRP-1:0] g;
        g[GRP_EOC] = l[SRC_EOC];
        g[GRP_SUP] = l[SRC_SUP];
        g[GRP_TMP] = l[SRC_TMP];
        g[GRP_TMR] = l[SRC_PRE] | l[SRC_TOT];
        return g;
    endfunction

    // per-group edge hit before the arm gate
    function automatic logic [NUM_GRP-1:0] group_edges(input src_view_t v, input edge_en_t e);
        logic [NUM_GRP-1:0] h;
        h[GRP_EOC] = (v.rise[SRC_EOC] & e.eoc_rise) | (v.fall[SRC_EOC] & e.eoc_fall);
        h[GRP_SUP] = (v.rise[SRC_SUP] & e.sup_rise) | (v.fall[SRC_SUP] & e.sup_fall);
        h[GRP_TMP] = (v.rise[SRC_TMP] & e.tmp_rise) | (v.fall[SRC_TMP] & e.tmp_fall);
        h[GRP_TMR] = (v.rise[SRC_PRE] & e.pre_rise) | (v.rise[SRC_TOT] & e.tot_rise);
        return h;
    endfunction

endpackage

// File: rtl/chg_src_sync.sv
module chg_src_sync
    import chg_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raw_i,
    output src_view_t          view_o
);
    localparam int LAST = STAGES - 1;

    logic [NUM_SRC-1:0] chain [STAGES];
    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[LAST];
    end

    assign view_o.lvl  = chain[LAST];
    assign view_o.rise = chain[LAST] & ~prev_q;
    assign view_o.fall = ~chain[LAST] & prev_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            view_o.rise[i] |=> !view_o.rise[i]); // R3
        AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            view_o.fall[i] |=> !view_o.fall[i]); // R4
    end

endmodule

// File: rtl/chg_flag_bank.sv
module chg_flag_bank
    import chg_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GRP-1:0] hit_i,
    input  logic               clr_i,
    output logic [NUM_GRP-1:0] flag_o
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           flag_o[g] <= 1'b0;
            else if (hit_i[g]) flag_o[g] <= 1'b1;   // event beats the clear
            else if (clr_i)    flag_o[g] <= 1'b0;
        end

        AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
            hit_i[g] |=> flag_o[g]); // R7
        AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !hit_i[g]) |=> !flag_o[g]); // R6
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!clr_i && !hit_i[g]) |=> $stable(flag_o[g])); // R3
    end

endmodule

// File: rtl/chg_reg_port.sv
module chg_reg_port
    import chg_irq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h78,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h79,
    parameter logic [ADDR_W-1:0] STATE_ADDR = 8'h7A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_GRP-1:0] flag_i,
    input  logic [NUM_GRP-1:0] lvl_i,
    input  logic [1:0]         cstate_i,
    input  logic               kind_i,
    output logic [DATA_W-1:0]  rdata_o,
    output edge_en_t           edge_en_o,
    output logic [NUM_GRP-1:0] arm_o,
    output logic               clr_o
);
    rsel_e sel;

    always_comb begin
        if      (addr_i == STAT_ADDR)  sel = RSEL_STAT;
        else if (addr_i == CTRL_ADDR)  sel = RSEL_CTRL;
        else if (addr_i == STATE_ADDR) sel = RSEL_STATE;
        else                           sel = RSEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_en_o <= '0;
            arm_o     <= '0;
        end else if (wr_i) begin
            if (sel == RSEL_CTRL) edge_en_o <= edge_en_t'(wdata_i);
            if (sel == RSEL_STAT) arm_o     <= wdata_i[DATA_W-1 -: NUM_GRP];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel)
                RSEL_STAT:  rdata_o = {flag_i, lvl_i};
                RSEL_CTRL:  rdata_o = edge_en_o;
                RSEL_STATE: rdata_o = {2'b00, cstate_i, 2'b00, kind_i, 1'b0};
                default:    rdata_o = '0;
            endcase
        end
    end

    assign clr_o = rd_i && (sel == RSEL_STAT);

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && sel == RSEL_CTRL) |=> $stable(edge_en_o)); // R10
    AST_ARM_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && sel == RSEL_STAT) |=> $stable(arm_o)); // R9

endmodule

// File: rtl/chg_evt_irq_ctrl.sv
module chg_evt_irq_ctrl
    import chg_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h78,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h79,
    parameter logic [ADDR_W-1:0] STATE_ADDR = 8'h7A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sup_ok_i,
    input  logic              tmp_ok_i,
    input  logic              eoc_i,
    input  logic              pre_tmo_i,
    input  logic              tot_tmo_i,
    input  logic              src_kind_i,
    input  logic [1:0]        chg_state_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              irq_n_o
);
    logic [NUM_SRC-1:0] raw;
    src_view_t          view;
    edge_en_t           edge_en;
    logic [NUM_GRP-1:0] arm, hit, flag;
    logic               clr;
    logic [1:0]         cstate_q;

    always_comb begin
        raw           = '0;
        raw[SRC_EOC]  = eoc_i;
        raw[SRC_SUP]  = sup_ok_i;
        raw[SRC_TMP]  = tmp_ok_i;
        raw[SRC_PRE]  = pre_tmo_i;
        raw[SRC_TOT]  = tot_tmo_i;
        raw[SRC_KIND] = src_kind_i;
    end

    always_ff @(posedge clk) begin
        if (rst) cstate_q <= '0;
        else     cstate_q <= chg_state_i;
    end

    chg_src_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .view_o (view)
    );

    assign hit = arm & group_edges(view, edge_en);

    chg_flag_bank flags_i (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .clr_i  (clr),
        .flag_o (flag)
    );

    chg_reg_port #(
        .ADDR_W     (ADDR_W),
        .STAT_ADDR  (STAT_ADDR),
        .CTRL_ADDR  (CTRL_ADDR),
        .STATE_ADDR (STATE_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .wdata_i   (reg_wdata_i),
        .flag_i    (flag),
        .lvl_i     (group_levels(view.lvl)),
        .cstate_i  (cstate_q),
        .kind_i    (view.lvl[SRC_KIND]),
        .rdata_o   (reg_rdata_o),
        .edge_en_o (edge_en),
        .arm_o     (arm),
        .clr_o     (clr)
    );

    assign irq_n_o = ~(|flag);

    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (arm == '0 && irq_n_o) |=> irq_n_o); // R5
    AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr && hit == '0) |=> irq_n_o); // R8
    AST_RAISE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> !irq_n_o); // R8

endmodule

// File: tb/chg_evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module chg_evt_irq_ctrl_tb_top;

    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;
    localparam logic [7:0] A_STAT  = 8'h78;
    localparam logic [7:0] A_CTRL  = 8'h79;
    localparam logic [7:0] A_STATE = 8'h7A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup = 0, tmp = 0, eoc = 0, pre = 0, tot = 0, kind = 0;
    logic [1:0] cst = 2'b00;
    logic [7:0] addr = '0, wdata = '0;
    logic wr = 0, rd = 0;
    logic [7:0] rdata;
    logic irq_n;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    chg_evt_irq_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .sup_ok_i    (sup),
        .tmp_ok_i    (tmp),
        .eoc_i       (eoc),
        .pre_tmo_i   (pre),
        .tot_tmo_i   (tot),
        .src_kind_i  (kind),
        .chg_state_i (cst),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL %s unexpected read: actual %02h expected none", "SB", rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (rdata !== it.val) begin
                    n_bad++;
                    $display("FAIL %s read: actual %02h expected %02h", it.tag, rdata, it.val);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        sb_item_t it;
        it.val = exp;
        it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd = 1'b1;
        step(1);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step(1);
        wr = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (irq_n !== exp) begin
            n_bad++;
            $display("FAIL %s irq_n: actual %0b expected %0b", tag, irq_n, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk_irq(1'b1, "R1");
        rd_reg(A_STAT, 8'h00, "R1");
        rd_reg(A_CTRL, 8'h00, "R1");

        // R2 levels, R5 nothing armed
        sup = 1; tmp = 1;
        step(LAT);
        rd_reg(A_STAT, 8'h06, "R2/R5");
        chk_irq(1'b1, "R5");

        // R9 edge-select readback and arm write with junk low bits
        wr_reg(A_CTRL, 8'hFF);
        rd_reg(A_CTRL, 8'hFF, "R9");
        wr_reg(A_STAT, 8'hF5);
        rd_reg(A_STAT, 8'h06, "R9");

        // R3 charge-complete entry, R6 clear on read, R8
        eoc = 1;
        step(LAT);
        chk_irq(1'b0, "R8");
        rd_reg(A_STAT, 8'h17, "R3");
        rd_reg(A_STAT, 8'h07, "R6");
        chk_irq(1'b1, "R8");

        // R4 supply disconnect
        sup = 0;
        step(LAT);
        rd_reg(A_STAT, 8'h25, "R4");

        // R5 edge enable off
        wr_reg(A_CTRL, 8'h00);
        tmp = 0;
        step(LAT);
        rd_reg(A_STAT, 8'h01, "R5");
        chk_irq(1'b1, "R5");

        // R11 timer sources with separate enables
        wr_reg(A_CTRL, 8'h08);
        tot = 1;
        step(LAT);
        rd_reg(A_STAT, 8'h09, "R11");
        pre = 1;
        step(LAT);
        rd_reg(A_STAT, 8'h89, "R11");
        wr_reg(A_CTRL, 8'h80);
        tot = 0;
        step(LAT);
        tot = 1;
        step(LAT);
        rd_reg(A_STAT, 8'h89, "R11");

        // R7 event coincides with the clearing read
        wr_reg(A_CTRL, 8'h22);
        sup = 1;
        step(LAT);
        chk_irq(1'b0, "R3");
        sup = 0;
        step(SYNC);
        rd_reg(A_STAT, 8'h29, "R7");
        chk_irq(1'b0, "R7");
        rd_reg(A_STAT, 8'h29, "R7");
        rd_reg(A_STAT, 8'h09, "R6");

        // R5 disarmed group with all enables
        wr_reg(A_STAT, 8'h00);
        wr_reg(A_CTRL, 8'hFF);
        eoc = 0;
        step(LAT);
        rd_reg(A_STAT, 8'h08, "R5");
        chk_irq(1'b1, "R5");

        // R10 state register, write ignored, unmapped read
        cst = 2'b10; kind = 1;
        step(LAT);
        rd_reg(A_STATE, 8'h22, "R10");
        wr_reg(A_STATE, 8'hFF);
        rd_reg(A_STATE, 8'h22, "R10");
        rd_reg(A_CTRL, 8'hFF, "R10");
        rd_reg(8'h55, 8'h00, "R10");

        step(2);
        if (sb_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL SB leftover: actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule